// File: doc/BRIEF.md
# Sixteen-Bit Event Timer with Shadowed High Byte

This block is a 16-bit up-counter that sits on an 8-bit register bus. Each count step comes from one of two sources: a free-running divide-by-four of the system clock, or rising edges on an external input. The external input may pass through a two-flop synchronizer, or it may be used as it arrives. A 2-bit field sets a prescale ratio of 1, 2, 4 or 8 between the source and the counter. An enable bit gates counting. When the count wraps from FFFFh to 0000h, a sticky overflow flag is set. That flag drives the interrupt output only while the interrupt enable bit is set. A one-cycle trigger input from a compare unit clears the count.

Software reaches the counter through four byte addresses. In shadowed mode the high-byte address reaches a buffer and not the live high byte. Reading the low byte copies the live high byte into that buffer, so a later high-byte read matches the low byte that was just read. Writing the low byte loads the live high byte from the buffer in the same cycle, so a 16-bit value lands all at once. With shadowed mode off, the high-byte address reaches the live high byte directly.

Rising-edge detection on the external source is a two-state machine. In EDGE_LOW, a high level moves it to EDGE_HIGH and emits a one-cycle rise pulse. A low level keeps it in EDGE_LOW. In EDGE_HIGH, a low level returns it to EDGE_LOW and a high level keeps it in EDGE_HIGH. Neither of these two transitions emits a pulse.

Top module: `tmr16_buffered`

## Requirements
- R1: After reset, all four registers read 00h, the shadow buffer holds 00h and irq is low.
- R2: Register addresses: 0 is the count low byte, 1 is the count high byte (or the shadow buffer), 2 is control, 3 is status. Control bits: bit0 enable, bit1 source (1 = external edges, 0 = system clock divided by 4), bit2 synchronize the external input, bits4:3 prescale select, bit7 shadowed mode. Status bits: bit0 overflow flag, bit1 interrupt enable.
- R3: With shadowed mode off, the high-byte address reads and writes the live high byte, and low-byte reads leave the shadow buffer unchanged.
- R4: With shadowed mode on, a low-byte read copies the live high byte into the buffer, and a high-byte read returns the buffer.
- R5: With shadowed mode on, a high-byte write changes only the buffer. A low-byte write loads the live high byte from the buffer and the low byte from the bus data in the same cycle.
- R6: Prescale select values 0, 1, 2 and 3 advance the count once per 1, 2, 4 and 8 source ticks respectively. The external source ticks on rising edges.
- R7: A low-byte write clears the prescaler. A high-byte write does not clear it.
- R8: With the internal source selected, the source ticks once every 4 system clocks.
- R9: With enable at 0, source ticks do not change the count.
- R10: External edges are counted both with and without synchronization. Each rising edge gives exactly one tick.
- R11: A wrap from FFFFh to 0000h sets the overflow flag. Writing 1 to status bit0 leaves the flag unchanged, and writing 0 clears it. irq equals flag AND interrupt enable.
- R12: A trigger pulse clears the 16-bit count to 0000h.
- R13: When a bus write to a count byte and an increment or trigger fall in the same cycle, the write wins and the increment is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_rdata | output | 8 | Read data, valid while bus_rd is high, otherwise 00h |
| ext_clk | input | 1 | External count source |
| trig_clear | input | 1 | Compare-unit trigger that clears the count |
| irq | output | 1 | Overflow interrupt request |

## Verification
The assertions assume that bus_rd and bus_wr are never high in the same cycle. They also assume that source or synchronizer selections change only while the external input is low, so the edge machine sees no false rise from a mode switch. The bench performs each access as a single strobe cycle driven on the falling edge. It changes control only with ext_clk low. It holds every external level for three clocks, which is longer than the two-flop synchronizer delay. The one deliberate collision is a low-byte write in the same cycle as an unsynchronized rising edge, which exercises the write-over-increment priority.

// File: rtl/tmr16_pkg.sv
package tmr16_pkg;

    typedef enum logic [1:0] {
        REG_CNT_LO = 2'd0,
        REG_CNT_HI = 2'd1,
        REG_CTRL   = 2'd2,
        REG_STAT   = 2'd3
    } reg_addr_e;

    typedef struct packed {
        logic       mode16;
        logic [1:0] spare;
        logic [1:0] ps;
        logic       sync;
        logic       ext;
        logic       en;
    } ctrl_t;

    typedef enum logic {
        EDGE_LOW  = 1'b0,
        EDGE_HIGH = 1'b1
    } edge_state_e;

endpackage

// File: rtl/tmr16_edge_fsm.sv
module tmr16_edge_fsm
    import tmr16_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sync_en,
    input  logic lvl_in,
    output logic rise
);
    logic [SYNC_STAGES-1:0] chain_q;
    logic                   lvl;
    edge_state_e            state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[SYNC_STAGES-2:0], lvl_in};
    end

    assign lvl = sync_en ? chain_q[SYNC_STAGES-1] : lvl_in;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= EDGE_LOW;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            EDGE_LOW:  state_d = lvl ? EDGE_HIGH : EDGE_LOW;
            EDGE_HIGH: state_d = lvl ? EDGE_HIGH : EDGE_LOW;
        endcase
    end

    // outputs
    always_comb begin
        rise = 1'b0;
        unique case (state_q)
            EDGE_LOW:  rise = lvl;
            EDGE_HIGH: rise = 1'b0;
        endcase
    end

    // R10: one tick per rising edge
    p_single_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);
    p_rise_enters_high_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> state_q == EDGE_HIGH);

endmodule

// File: rtl/tmr16_tick_gen.sv
module tmr16_tick_gen #(
    parameter int PS_W        = 2,
    parameter int DIV_INT     = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en,
    input  logic            use_ext,
    input  logic            sync_ext,
    input  logic [PS_W-1:0] ps,
    input  logic            ext_clk,
    input  logic            clr_pre,
    output logic            count_tick
);
    localparam int DIV_W = (DIV_INT > 2) ? $clog2(DIV_INT) : 1;
    localparam int PRE_W = (1 << PS_W) - 1;

    logic [DIV_W-1:0] div_q;
    logic             int_tick;
    logic             ext_rise;
    logic             src_tick;
    logic [PRE_W-1:0] pre_q;
    logic [PRE_W-1:0] mask;

    always_ff @(posedge clk) begin
        if (!rst_n)                               div_q <= '0;
        else if (div_q == DIV_W'(DIV_INT - 1))    div_q <= '0;
        else                                      div_q <= div_q + 1'b1;
    end
    assign int_tick = (div_q == DIV_W'(DIV_INT - 1));

    tmr16_edge_fsm #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .sync_en (sync_ext),
        .lvl_in  (ext_clk),
        .rise    (ext_rise)
    );

    assign src_tick = use_ext ? ext_rise : int_tick;

    always_comb begin
        for (int i = 0; i < PRE_W; i++) mask[i] = (i < int'(ps));
    end

    always_ff @(posedge clk) begin
        if (!rst_n || clr_pre)    pre_q <= '0;
        else if (en && src_tick)  pre_q <= pre_q + 1'b1;
    end

    assign count_tick = en && src_tick && ((pre_q & mask) == mask);

    // R7: a low-byte write leaves the prescaler at zero
    p_prescale_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        clr_pre |=> pre_q == '0);
    // R8: internal ticks are never back to back
    p_internal_spacing_r8: assert property (@(posedge clk) disable iff (!rst_n)
        int_tick |=> !int_tick);

endmodule

// File: rtl/tmr16_count_core.sv
module tmr16_count_core #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_lo,
    input  logic              wr_hi_live,
    input  logic              mode16,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] hbuf,
    input  logic              inc,
    input  logic              trig,
    output logic [2*DATA_W-1:0] cnt,
    output logic              ovf
);
    localparam int CNT_W = 2 * DATA_W;

    logic [CNT_W-1:0] cnt_q;
    logic             bus_wins;

    assign bus_wins = wr_lo || wr_hi_live;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (wr_lo) begin
            cnt_q <= {(mode16 ? hbuf : cnt_q[CNT_W-1:DATA_W]), wdata};
        end else if (wr_hi_live) begin
            cnt_q[CNT_W-1:DATA_W] <= wdata;
        end else if (trig) begin
            cnt_q <= '0;
        end else if (inc) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign cnt = cnt_q;
    assign ovf = inc && !bus_wins && !trig && (cnt_q == {CNT_W{1'b1}});

    // R13: bus write beats increment
    p_lo_write_wins_r13: assert property (@(posedge clk) disable iff (!rst_n)
        wr_lo |=> cnt_q[DATA_W-1:0] == $past(wdata));
    // R12: trigger clears the count
    p_trigger_clear_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (trig && !bus_wins) |=> cnt_q == '0);
    // R11: wrap lands on zero
    p_wrap_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |=> cnt_q == '0);
    // R9: without a tick or access, count holds
    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!inc && !bus_wins && !trig) |=> $stable(cnt_q));

endmodule

// File: rtl/tmr16_bus_regs.sv
module tmr16_bus_regs
    import tmr16_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 2,
    parameter int PS_W   = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [DATA_W-1:0]   bus_wdata,
    input  logic                bus_wr,
    input  logic                bus_rd,
    output logic [DATA_W-1:0]   bus_rdata,
    input  logic [2*DATA_W-1:0] cnt,
    input  logic                ovf,
    output logic                en,
    output logic                use_ext,
    output logic                sync_ext,
    output logic [PS_W-1:0]     ps,
    output logic                mode16,
    output logic [DATA_W-1:0]   hbuf,
    output logic                wr_lo,
    output logic                wr_hi_live,
    output logic                clr_pre,
    output logic                irq
);
    localparam int CNT_W = 2 * DATA_W;

    ctrl_t             ctrl_q;
    logic [DATA_W-1:0] hbuf_q;
    logic              flag_q, ie_q;
    logic              sel_lo, sel_hi, sel_ctrl, sel_stat;
    logic              rd_lo, wr_hi_buf, wr_stat;

    assign sel_lo   = (bus_addr == ADDR_W'(REG_CNT_LO));
    assign sel_hi   = (bus_addr == ADDR_W'(REG_CNT_HI));
    assign sel_ctrl = (bus_addr == ADDR_W'(REG_CTRL));
    assign sel_stat = (bus_addr == ADDR_W'(REG_STAT));

    assign wr_lo      = bus_wr && sel_lo;
    assign wr_hi_live = bus_wr && sel_hi && !ctrl_q.mode16;
    assign wr_hi_buf  = bus_wr && sel_hi &&  ctrl_q.mode16;
    assign wr_stat    = bus_wr && sel_stat;
    assign rd_lo      = bus_rd && !bus_wr && sel_lo;
    assign clr_pre    = wr_lo;

    always_ff @(posedge clk) begin
        if (!rst_n)                       ctrl_q <= '0;
        else if (bus_wr && sel_ctrl)      ctrl_q <= ctrl_t'(bus_wdata[7:0]);
    end

    always_ff @(posedge clk) begin
        if (!rst_n)                       hbuf_q <= '0;
        else if (wr_hi_buf)               hbuf_q <= bus_wdata;
        else if (rd_lo && ctrl_q.mode16)  hbuf_q <= cnt[CNT_W-1:DATA_W];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
            ie_q   <= 1'b0;
        end else begin
            if (wr_stat) ie_q <= bus_wdata[1];
            if (ovf)                           flag_q <= 1'b1;
            else if (wr_stat && !bus_wdata[0]) flag_q <= 1'b0;
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            unique case (1'b1)
                sel_lo:   bus_rdata = cnt[DATA_W-1:0];
                sel_hi:   bus_rdata = ctrl_q.mode16 ? hbuf_q : cnt[CNT_W-1:DATA_W];
                sel_ctrl: bus_rdata = DATA_W'(ctrl_q);
                sel_stat: bus_rdata = DATA_W'({ie_q, flag_q});
            endcase
        end
    end

    assign en       = ctrl_q.en;
    assign use_ext  = ctrl_q.ext;
    assign sync_ext = ctrl_q.sync;
    assign ps       = ctrl_q.ps;
    assign mode16   = ctrl_q.mode16;
    assign hbuf     = hbuf_q;
    assign irq      = flag_q && ie_q;

    // R4: low-byte read in shadowed mode captures live high byte
    p_buffer_latch_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_lo && ctrl_q.mode16) |=> hbuf_q == $past(cnt[CNT_W-1:DATA_W]));
    // R3: low-byte read outside shadowed mode keeps the buffer
    p_buffer_keep_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_lo && !ctrl_q.mode16) |=> $stable(hbuf_q));
    // R11: overflow sets the flag, and it stays until a zero is written
    p_flag_set_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |=> flag_q);
    p_flag_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && !(wr_stat && !bus_wdata[0])) |=> flag_q);
    p_no_irq_without_enable_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !ie_q |-> !irq);
    p_bus_exclusive_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_rd && bus_wr));

endmodule

// File: rtl/tmr16_buffered.sv
module tmr16_buffered
    import tmr16_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int ADDR_W      = 2,
    parameter int PS_W        = 2,
    parameter int DIV_INT     = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_wr,
    input  logic              bus_rd,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              ext_clk,
    input  logic              trig_clear,
    output logic              irq
);
    localparam int CNT_W = 2 * DATA_W;

    logic [CNT_W-1:0]  cnt;
    logic              ovf;
    logic              en, use_ext, sync_ext, mode16;
    logic [PS_W-1:0]   ps;
    logic [DATA_W-1:0] hbuf;
    logic              wr_lo, wr_hi_live, clr_pre;
    logic              count_tick;

    tmr16_bus_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .PS_W(PS_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_wr     (bus_wr),
        .bus_rd     (bus_rd),
        .bus_rdata  (bus_rdata),
        .cnt        (cnt),
        .ovf        (ovf),
        .en         (en),
        .use_ext    (use_ext),
        .sync_ext   (sync_ext),
        .ps         (ps),
        .mode16     (mode16),
        .hbuf       (hbuf),
        .wr_lo      (wr_lo),
        .wr_hi_live (wr_hi_live),
        .clr_pre    (clr_pre),
        .irq        (irq)
    );

    tmr16_tick_gen #(.PS_W(PS_W), .DIV_INT(DIV_INT), .SYNC_STAGES(SYNC_STAGES)) u_tick (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (en),
        .use_ext    (use_ext),
        .sync_ext   (sync_ext),
        .ps         (ps),
        .ext_clk    (ext_clk),
        .clr_pre    (clr_pre),
        .count_tick (count_tick)
    );

    tmr16_count_core #(.DATA_W(DATA_W)) u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_lo      (wr_lo),
        .wr_hi_live (wr_hi_live),
        .mode16     (mode16),
        .wdata      (bus_wdata),
        .hbuf       (hbuf),
        .inc        (count_tick),
        .trig       (trig_clear),
        .cnt        (cnt),
        .ovf        (ovf)
    );

endmodule

// File: tb/tmr16_buffered_test.sv
`timescale 1ns/1ps
module tmr16_buffered_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_rdata;
    logic       ext_clk = 1'b0;
    logic       trig_clear = 1'b0;
    logic       irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    localparam logic [1:0] A_LO = 2'd0, A_HI = 2'd1, A_CTRL = 2'd2, A_STAT = 2'd3;

    always #2.5 clk = ~clk;

    tmr16_buffered uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .ext_clk(ext_clk), .trig_clear(trig_clear), .irq(irq)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic ext_edges(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); ext_clk = 1'b1;
            repeat (3) @(negedge clk);
            ext_clk = 1'b0;
            repeat (3) @(negedge clk);
        end
        repeat (4) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [7:0] d;
        rd(A_LO, d);   chk("R1 low", d, 8'h00);
        rd(A_HI, d);   chk("R1 high", d, 8'h00);
        rd(A_CTRL, d); chk("R1 ctrl", d, 8'h00);
        rd(A_STAT, d); chk("R1 status", d, 8'h00);
        chk("R1 irq", {7'd0, irq}, 8'h00);
    endtask

    task automatic t_shadow();
        logic [7:0] d;
        wr(A_CTRL, 8'h80);
        wr(A_HI, 8'h34); wr(A_LO, 8'hAB);
        wr(A_CTRL, 8'h00);
        rd(A_HI, d); chk("R5 commit high", d, 8'h34);
        rd(A_LO, d); chk("R2 low byte", d, 8'hAB);
        wr(A_HI, 8'h77);
        rd(A_HI, d); chk("R3 live high write", d, 8'h77);
        wr(A_CTRL, 8'h80);
        rd(A_HI, d); chk("R4 buffer not live", d, 8'h34);
        rd(A_LO, d); chk("R4 low read", d, 8'hAB);
        rd(A_HI, d); chk("R4 latched high", d, 8'h77);
        wr(A_CTRL, 8'h00);
        wr(A_HI, 8'h11);
        rd(A_LO, d);
        wr(A_CTRL, 8'h80);
        rd(A_HI, d); chk("R3 low read keeps buffer", d, 8'h77);
        wr(A_HI, 8'h99);
        wr(A_CTRL, 8'h00);
        rd(A_HI, d); chk("R5 buffer write not live", d, 8'h11);
        wr(A_CTRL, 8'h80);
        wr(A_LO, 8'h00);
        wr(A_CTRL, 8'h00);
        rd(A_HI, d); chk("R5 low write commits", d, 8'h99);
        rd(A_CTRL, d); chk("R2 ctrl readback", d, 8'h00);
    endtask

    task automatic t_prescale();
        logic [7:0] d;
        for (int k = 0; k < 4; k++) begin
            wr(A_CTRL, 8'((k << 3) | 7));
            wr(A_HI, 8'h00); wr(A_LO, 8'h00);
            ext_edges(16);
            rd(A_LO, d); chk($sformatf("R6 ratio sel %0d", k), d, 8'(16 >> k));
        end
    endtask

    task automatic t_prescale_clear();
        logic [7:0] d;
        wr(A_CTRL, 8'h17);
        wr(A_LO, 8'h00);
        ext_edges(2); wr(A_HI, 8'h00); ext_edges(2);
        rd(A_LO, d); chk("R7 high write keeps prescaler", d, 8'h01);
        wr(A_LO, 8'h00);
        ext_edges(2); wr(A_LO, 8'h00); ext_edges(2);
        rd(A_LO, d); chk("R7 low write clears prescaler", d, 8'h00);
    endtask

    task automatic t_internal();
        logic [7:0] d;
        wr(A_CTRL, 8'h01);
        wr(A_HI, 8'h00); wr(A_LO, 8'h00);
        repeat (80) @(negedge clk);
        rd(A_LO, d);
        checks++;
        if (d < 8'd19 || d > 8'd21) begin
            fails++; $display("FAIL R8 div4: actual %0d expected 19..21", d);
        end
        wr(A_CTRL, 8'h09);
        wr(A_LO, 8'h00);
        repeat (160) @(negedge clk);
        rd(A_LO, d);
        checks++;
        if (d < 8'd19 || d > 8'd21) begin
            fails++; $display("FAIL R8 div4 prescale2: actual %0d expected 19..21", d);
        end
        wr(A_CTRL, 8'h00);
    endtask

    task automatic t_enable();
        logic [7:0] d;
        wr(A_CTRL, 8'h06);
        wr(A_HI, 8'h00); wr(A_LO, 8'h05);
        ext_edges(3);
        rd(A_LO, d); chk("R9 disabled holds", d, 8'h05);
    endtask

    task automatic t_unsync_priority();
        logic [7:0] d;
        wr(A_CTRL, 8'h03);
        wr(A_LO, 8'h10);
        ext_edges(3);
        rd(A_LO, d); chk("R10 unsynchronized edges", d, 8'h13);
        @(negedge clk);
        ext_clk = 1'b1; bus_addr = A_LO; bus_wdata = 8'h55; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        repeat (2) @(negedge clk);
        ext_clk = 1'b0;
        repeat (2) @(negedge clk);
        rd(A_LO, d); chk("R13 write beats increment", d, 8'h55);
        wr(A_CTRL, 8'h00);
    endtask

    task automatic t_overflow();
        logic [7:0] d;
        wr(A_CTRL, 8'h07);
        wr(A_HI, 8'hFF); wr(A_LO, 8'hFF);
        ext_edges(1);
        rd(A_LO, d); chk("R11 wrap low", d, 8'h00);
        rd(A_HI, d); chk("R11 wrap high", d, 8'h00);
        rd(A_STAT, d); chk("R11 flag set", d, 8'h01);
        chk("R11 irq gated off", {7'd0, irq}, 8'h00);
        wr(A_STAT, 8'h03);
        @(negedge clk);
        chk("R11 irq on", {7'd0, irq}, 8'h01);
        rd(A_STAT, d); chk("R11 write one keeps flag", d, 8'h03);
        wr(A_STAT, 8'h02);
        @(negedge clk);
        rd(A_STAT, d); chk("R11 write zero clears", d, 8'h02);
        chk("R11 irq off", {7'd0, irq}, 8'h00);
        wr(A_CTRL, 8'h00);
    endtask

    task automatic t_trigger();
        logic [7:0] d;
        wr(A_HI, 8'h12); wr(A_LO, 8'h34);
        @(negedge clk); trig_clear = 1'b1;
        @(negedge clk); trig_clear = 1'b0;
        rd(A_LO, d); chk("R12 trigger low", d, 8'h00);
        rd(A_HI, d); chk("R12 trigger high", d, 8'h00);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_shadow();
        t_prescale();
        t_prescale_clear();
        t_internal();
        t_enable();
        t_unsync_priority();
        t_overflow();
        t_trigger();
        finish_run();
    end

endmodule